// File: doc/BRIEF.md
# Biphase Word Transmitter with Channel and Loopback Steering

This block turns 16-bit words into a serial Manchester II biphase stream of the kind used on dual-redundant avionics serial buses. Each word is framed by a three-bit-time sync field at the front and an odd parity bit at the back, which gives 20 bit times per word. The block runs on a 12 MHz system clock. A bit lasts 12 clocks, and each half-bit lasts 6 clocks. The bench runs the block at a faster clock, but all timing is counted in clocks.

A single encoder feeds four possible destinations. Two of them are the complementary drive pairs of bus channels A and B. The other two are single-line loopback streams that go into the receive path of channel A or channel B during self-test. A pending-word slot sits in front of the shifter. The host can therefore queue the next word while the current word is still going out, and the queued word follows with no idle gap. A strobe that arrives while the slot is already full is dropped, and the block flags it.

Control is a four-state machine:
- `ST_IDLE` waits for the pending slot to fill. Taking a queued word moves the block to `ST_SYNC`.
- `ST_SYNC` sends the sync field. After three bit times it moves to `ST_DATA`.
- `ST_DATA` shifts out 16 bits, MSB first. After the last bit it moves to `ST_PARITY`.
- `ST_PARITY` sends one parity bit. When it ends, the block returns to `ST_SYNC` if a word is pending, and to `ST_IDLE` otherwise.

Top module: `biphase_tx_router`

## Requirements
- R1: With `sync_cmd`=1, the sync field is 18 clocks high followed by 18 clocks low.
- R2: With `sync_cmd`=0, the sync field is inverted: 18 clocks low followed by 18 clocks high.
- R3: The 16 data bits follow the sync field, MSB (`word_in[15]`) first, at 12 clocks per bit. A 1 is 6 clocks high then 6 clocks low. A 0 is 6 clocks low then 6 clocks high.
- R4: One parity bit follows the data, encoded the same way. Its value makes the number of ones across the 16 data bits plus the parity bit odd.
- R5: While a word is being sent, exactly one destination carries it. The destination is channel A (`chan_sel`=0) or channel B (`chan_sel`=1). On a bus pair, `_p` carries the stream level and `_n` carries its complement.
- R6: With `self_test`=1, the stream goes to `loop_a` or `loop_b` according to `chan_sel`, and all four bus lines stay low.
- R7: When nothing is being sent, all bus lines and loopback lines are low, and `busy` is low.
- R8: A `start` accepted while a word is being sent is held in the slot. It is sent immediately after the current word's parity bit, with no idle clock between the two words.
- R9: A `start` seen while the slot is full is ignored: that word is never sent. `overrun` goes high for exactly the one clock that follows.
- R10: `done` is high for exactly one clock, in the clock right after a word's final parity half-bit.
- R11: `busy` is high from the clock after an accepted `start` until the last word has ended. It falls in the same clock that `done` rises.
- R12: The first level of a word appears two clocks after the edge that samples an accepted `start`, provided the block was idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Strobe that queues `word_in` together with its options |
| word_in | input | 16 | Word to send |
| sync_cmd | input | 1 | 1 selects the command/status sync, 0 selects the data sync |
| chan_sel | input | 1 | 0 selects channel A, 1 selects channel B |
| self_test | input | 1 | 1 routes the stream to the loopback line of the selected channel |
| bus_a_p | output | 1 | Channel A drive, true level |
| bus_a_n | output | 1 | Channel A drive, complement |
| bus_b_p | output | 1 | Channel B drive, true level |
| bus_b_n | output | 1 | Channel B drive, complement |
| loop_a | output | 1 | Loopback stream into the channel A receive path |
| loop_b | output | 1 | Loopback stream into the channel B receive path |
| busy | output | 1 | A word is queued or being sent |
| done | output | 1 | One-clock pulse at the end of each word |
| overrun | output | 1 | One-clock pulse after a dropped start |

## Verification
Every one of the 240 clocks of each word is compared with a waveform built from the requirements. A mismatch in sync polarity, bit order, half-bit length, parity sense or routing therefore shows up at a specific clock. All-zero, all-one and single-one words are used to separate even from odd parity and the MSB from the LSB. Seeded random words, together with random sync type, channel and self-test choices, cover all four destinations under both sync types. A back-to-back sequence with a third, colliding strobe shows whether the gapless hand-off, the drop of the extra word and the one-clock `overrun` and `done` pulses all behave as required.

// File: rtl/biphase_pkg.sv
package biphase_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SYNC   = 2'd1,
        ST_DATA   = 2'd2,
        ST_PARITY = 2'd3
    } tx_state_e;

    localparam int SYNC_BITS = 3;
endpackage

// File: rtl/half_bit_timer.sv
module half_bit_timer #(
    parameter int HALF_CLKS = 6,
    localparam int BIT_CLKS = 2 * HALF_CLKS,
    localparam int TICK_W   = $clog2(BIT_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [TICK_W-1:0] tick,
    output logic              first_half,
    output logic              bit_end
);
    logic [TICK_W-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else if (!run) begin
            tick_q <= '0;
        end else if (tick_q == TICK_W'(BIT_CLKS - 1)) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign tick       = tick_q;
    assign first_half = (tick_q < TICK_W'(HALF_CLKS));
    assign bit_end    = run && (tick_q == TICK_W'(BIT_CLKS - 1));
endmodule

// File: rtl/word_slot.sv
module word_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word_in,
    input  logic              sync_cmd,
    input  logic              chan_sel,
    input  logic              self_test,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] word_out,
    output logic              cmd_out,
    output logic              chan_out,
    output logic              st_out,
    output logic              overrun
);
    logic              valid_q;
    logic              ovr_q;
    logic [DATA_W-1:0] word_q;
    logic              cmd_q;
    logic              chan_q;
    logic              st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
            word_q  <= '0;
            cmd_q   <= 1'b0;
            chan_q  <= 1'b0;
            st_q    <= 1'b0;
        end else begin
            ovr_q <= start && valid_q;
            if (start && !valid_q) begin
                valid_q <= 1'b1;
                word_q  <= word_in;
                cmd_q   <= sync_cmd;
                chan_q  <= chan_sel;
                st_q    <= self_test;
            end else if (take) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign valid    = valid_q;
    assign word_out = word_q;
    assign cmd_out  = cmd_q;
    assign chan_out = chan_q;
    assign st_out   = st_q;
    assign overrun  = ovr_q;
endmodule

// File: rtl/lane_router.sv
module lane_router #(
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic            en,
    input  logic            lvl,
    input  logic            self_test,
    input  logic [CH_W-1:0] sel,
    output logic [NUM_CH-1:0] bus_p,
    output logic [NUM_CH-1:0] bus_n,
    output logic [NUM_CH-1:0] loopback
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        logic hit;
        assign hit         = en && (sel == CH_W'(i));
        assign bus_p[i]    = hit && !self_test && lvl;
        assign bus_n[i]    = hit && !self_test && !lvl;
        assign loopback[i] = hit && self_test && lvl;
    end
endmodule

// File: rtl/biphase_tx_router.sv
module biphase_tx_router
    import biphase_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int HALF_CLKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] word_in,
    input  logic              sync_cmd,
    input  logic              chan_sel,
    input  logic              self_test,
    output logic              bus_a_p,
    output logic              bus_a_n,
    output logic              bus_b_p,
    output logic              bus_b_n,
    output logic              loop_a,
    output logic              loop_b,
    output logic              busy,
    output logic              done,
    output logic              overrun
);
    localparam int BIT_CLKS  = 2 * HALF_CLKS;
    localparam int TICK_W    = $clog2(BIT_CLKS);
    localparam int IDX_W     = $clog2(DATA_W + 1);
    localparam int SYNC_HALF = SYNC_BITS * BIT_CLKS / 2;

    tx_state_e         state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              act_cmd_q, act_chan_q, act_st_q;
    logic              done_q;

    logic              pend_valid, pend_cmd, pend_chan, pend_st;
    logic [DATA_W-1:0] pend_word;
    logic              take;
    logic [TICK_W-1:0] tick;
    logic              first_half, bit_end;
    logic              run;
    logic              lvl;
    logic [1:0]        bp, bn, lp;

    word_slot #(.DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .word_in  (word_in),
        .sync_cmd (sync_cmd),
        .chan_sel (chan_sel),
        .self_test(self_test),
        .take     (take),
        .valid    (pend_valid),
        .word_out (pend_word),
        .cmd_out  (pend_cmd),
        .chan_out (pend_chan),
        .st_out   (pend_st),
        .overrun  (overrun)
    );

    assign run = (state_q != ST_IDLE);

    half_bit_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .first_half(first_half),
        .bit_end   (bit_end)
    );

    // next-state process
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_valid) begin
                    state_d = ST_SYNC;
                    idx_d   = '0;
                    take    = 1'b1;
                end
            end
            ST_SYNC: begin
                if (bit_end) begin
                    if (idx_q == IDX_W'(SYNC_BITS - 1)) begin
                        state_d = ST_DATA;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (idx_q == IDX_W'(DATA_W - 1)) begin
                        state_d = ST_PARITY;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PARITY: begin
                if (bit_end) begin
                    idx_d = '0;
                    if (pend_valid) begin
                        state_d = ST_SYNC;
                        take    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            shreg_q    <= '0;
            par_q      <= 1'b0;
            act_cmd_q  <= 1'b0;
            act_chan_q <= 1'b0;
            act_st_q   <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            done_q  <= (state_q == ST_PARITY) && bit_end;
            if (take) begin
                shreg_q    <= pend_word;
                par_q      <= ~^pend_word;
                act_cmd_q  <= pend_cmd;
                act_chan_q <= pend_chan;
                act_st_q   <= pend_st;
            end else if ((state_q == ST_DATA) && bit_end) begin
                shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    // output process
    always_comb begin
        int sync_pos;
        sync_pos = int'(idx_q) * BIT_CLKS + int'(tick);
        lvl      = 1'b0;
        unique case (state_q)
            ST_IDLE:   lvl = 1'b0;
            ST_SYNC:   lvl = act_cmd_q ? (sync_pos < SYNC_HALF) : (sync_pos >= SYNC_HALF);
            ST_DATA:   lvl = first_half ? shreg_q[DATA_W-1] : !shreg_q[DATA_W-1];
            ST_PARITY: lvl = first_half ? par_q : !par_q;
            default:   lvl = 1'b0;
        endcase
    end

    lane_router #(.NUM_CH(2)) u_router (
        .en       (run),
        .lvl      (lvl),
        .self_test(act_st_q),
        .sel      (act_chan_q),
        .bus_p    (bp),
        .bus_n    (bn),
        .loopback (lp)
    );

    assign bus_a_p = bp[0];
    assign bus_a_n = bn[0];
    assign bus_b_p = bp[1];
    assign bus_b_n = bn[1];
    assign loop_a  = lp[0];
    assign loop_b  = lp[1];
    assign busy    = run || pend_valid;
    assign done    = done_q;
endmodule

// File: rtl/biphase_tx_router_chk.sv
module biphase_tx_router_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bus_a_p,
    input logic bus_a_n,
    input logic bus_b_p,
    input logic bus_b_n,
    input logic loop_a,
    input logic loop_b,
    input logic busy,
    input logic done,
    input logic overrun
);
    // R5
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_a_p | bus_a_n, bus_b_p | bus_b_n, loop_a, loop_b}));

    // R5
    pair_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_a_p && bus_a_n));

    // R5
    pair_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_b_p && bus_b_n));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_a_p || bus_a_n || bus_b_p || bus_b_n || loop_a || loop_b));

    // R9
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(start));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

bind biphase_tx_router biphase_tx_router_chk u_chk (.*);

// File: tb/biphase_tx_router_bench.sv
module biphase_tx_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] word_in = '0;
    logic        sync_cmd = 1'b0;
    logic        chan_sel = 1'b0;
    logic        self_test = 1'b0;
    logic        bus_a_p, bus_a_n, bus_b_p, bus_b_n, loop_a, loop_b;
    logic        busy, done, overrun;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    biphase_tx_router u_biphase_tx_router (
        .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in),
        .sync_cmd(sync_cmd), .chan_sel(chan_sel), .self_test(self_test),
        .bus_a_p(bus_a_p), .bus_a_n(bus_a_n), .bus_b_p(bus_b_p), .bus_b_n(bus_b_n),
        .loop_a(loop_a), .loop_b(loop_b), .busy(busy), .done(done), .overrun(overrun)
    );

    function automatic logic exp_level(logic [15:0] w, logic cmd, int k);
        logic b;
        logic early;
        if (k < 36) begin
            early = (k < 18);
            return cmd ? early : !early;
        end else if (k < 228) begin
            b = w[15 - (k - 36) / 12];
            return (((k - 36) % 12) < 6) ? b : !b;
        end else begin
            b = ~^w;
            return (((k - 228) % 12) < 6) ? b : !b;
        end
    endfunction

    function automatic logic [5:0] exp_outs(logic lv, logic ch, logic st);
        if (st) return ch ? {4'b0000, 1'b0, lv} : {4'b0000, lv, 1'b0};
        if (ch) return {2'b00, lv, !lv, 2'b00};
        return {lv, !lv, 4'b0000};
    endfunction

    function automatic logic [5:0] outs();
        return {bus_a_p, bus_a_n, bus_b_p, bus_b_n, loop_a, loop_b};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Called positioned at the negedge of sample 0; returns at the negedge after the last sample.
    task automatic watch(logic [15:0] w, logic cmd, logic ch, logic st);
        int    bad_k = -1;
        logic [5:0] got = '0, want = '0;
        for (int k = 0; k < 240; k++) begin
            logic [5:0] e;
            e = exp_outs(exp_level(w, cmd, k), ch, st);
            if ((outs() !== e || busy !== 1'b1) && bad_k < 0) begin
                bad_k = k; got = outs(); want = e;
            end
            if (k < 239) @(negedge clk);
        end
        // R1 R2 R3 R4 R5 R6: whole waveform of this word
        n_vec++;
        if (bad_k >= 0) begin
            n_bad++;
            $display("FAIL R1/R2/R3/R4/R5/R6 word=%h clk=%0d actual=%b expected=%b busy=%b",
                     w, bad_k, got, want, busy);
        end
        @(negedge clk);
        check("R10 done pulse", 32'(done), 32'd1);
    endtask

    task automatic drive(logic [15:0] w, logic cmd, logic ch, logic st);
        word_in = w; sync_cmd = cmd; chan_sel = ch; self_test = st; start = 1'b1;
    endtask

    task automatic send(logic [15:0] w, logic cmd, logic ch, logic st);
        drive(w, cmd, ch, st);
        @(negedge clk);
        start = 1'b0;
        check("R11 busy after accept", 32'(busy), 32'd1);
        check("R12 quiet before first level", 32'(outs()), 32'd0);
        @(negedge clk);
        watch(w, cmd, ch, st);
        @(negedge clk);
        check("R7 idle outputs", 32'({outs(), busy}), 32'd0);
        check("R10 done one clock", 32'(done), 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset outputs", 32'({outs(), busy, done, overrun}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        send(16'h0000, 1'b1, 1'b0, 1'b0);   // R1 R4: parity 1
        send(16'hFFFF, 1'b0, 1'b1, 1'b0);   // R2 R4: parity 1
        send(16'h0001, 1'b1, 1'b1, 1'b0);   // R3 LSB last, parity 0
        send(16'h8000, 1'b0, 1'b0, 1'b1);   // R3 MSB first, R6 loop A
        send(16'hA5C3, 1'b1, 1'b1, 1'b1);   // R6 loop B

        // R8 R9: back-to-back with a colliding third strobe
        drive(16'h1234, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        fork
            begin
                watch(16'h1234, 1'b1, 1'b0, 1'b0);
                watch(16'hBEEF, 1'b0, 1'b1, 1'b1);   // R8: no gap
            end
            begin
                repeat (40) @(negedge clk);
                drive(16'hBEEF, 1'b0, 1'b1, 1'b1);
                @(negedge clk);
                start = 1'b0;
                check("R9 no overrun on accept", 32'(overrun), 32'd0);
                repeat (5) @(negedge clk);
                drive(16'h0F0F, 1'b1, 1'b0, 1'b0);
                @(negedge clk);
                start = 1'b0;
                check("R9 overrun pulse", 32'(overrun), 32'd1);
                @(negedge clk);
                check("R9 overrun one clock", 32'(overrun), 32'd0);
            end
        join
        @(negedge clk);
        // R9: dropped word must not appear
        check("R9 dropped word not sent", 32'({outs(), busy}), 32'd0);

        // constrained random words
        for (int i = 0; i < 14; i++) begin
            logic [15:0] w;
            logic c, ch, st;
            w  = 16'($urandom);
            c  = 1'($urandom);
            ch = 1'($urandom);
            st = ($urandom % 4) == 0;
            send(w, c, ch, st);
        end

        finish_run();
    end
endmodule